// File: doc/BRIEF.md
# Serial Word Receiver with Mute and Hardware Wakeup

This block receives asynchronous serial words from a single RX line. A free-running bit-rate pulse (`bit_tick`), produced elsewhere, marks the instants at which the line is sampled, one sample per bit. A word consists of a low start bit, `DATA_BITS` data bits sent least significant bit first, and a high stop bit. When a word ends with a valid stop bit, it is moved into a receive data register and a full flag rises. The block also flags overrun, which means a word arrived while the register was still unread. It flags an idle line when the line stays high for one whole frame time after a delivered word. Each class of event has its own interrupt enable, and the enabled events drive a single interrupt output.

A mute mode lets a node that listens to a multi-drop line ignore traffic meant for other nodes. While muted, received words raise no flag. Hardware leaves mute mode by itself when it detects a wakeup condition. The `wake_addr` input selects that condition: either an idle line or a word whose most significant bit is set, which serves as an address mark. Software writes to the mute bit follow guard rules, so that the node cannot mute itself in a state from which the chosen wakeup could never release it.

Top module: `uart_mute_rx`

## Requirements
- R1: After reset, `rx_full`, `rx_ovr`, `idle_flag`, `mute_on` and `irq` are 0.
- R2: The line is sampled only on cycles with `bit_tick`=1. A low sample while waiting begins a word. The next `DATA_BITS` samples are data, least significant bit first, and the sample after them is the stop bit. With a high stop bit the word is loaded into `rx_data` and `rx_full` becomes 1. With a low stop bit the word is dropped and no flag changes.
- R3: While `rx_en`=0 no word is received and no idle line is detected. The flags keep their values.
- R4: A `data_rd` pulse clears `rx_full` and `rx_ovr`. If the pulse falls in the same cycle that a completed word is handed over, the new word is loaded, `rx_full` stays 1 and `rx_ovr` stays 0.
- R5: A word that completes while `rx_full`=1 with no read in that cycle sets `rx_ovr`=1 and is discarded, so `rx_data` keeps the older word.
- R6: After a delivered word, `DATA_BITS`+2 consecutive high samples taken while waiting for a start bit set `idle_flag`=1. One fewer high sample does not set it. No idle flag is raised before the first delivered word, and at most one is raised per delivered word. `idle_clr` clears it.
- R7: `irq` is 1 exactly when (`irq_en_rx` and (`rx_full` or `rx_ovr`)) or (`irq_en_idle` and `idle_flag`).
- R8: While `mute_on`=1, a word that does not wake the block sets no flag and leaves `rx_data` unchanged. An idle line sets no `idle_flag`.
- R9: With `wake_addr`=1, a word whose most significant bit is 1, received while muted, clears `mute_on` and is delivered normally (`rx_data` loaded, `rx_full`=1).
- R10: With `wake_addr`=0, detection of an idle line while muted clears `mute_on` and does not set `idle_flag`.
- R11: With `wake_addr`=1, a `mute_wr` pulse is ignored while `rx_full`=1.
- R12: With `wake_addr`=0, a `mute_wr` that sets mute is ignored until at least one word with a valid stop bit has completed since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit period; the line is sampled on it |
| rx | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| wake_addr | input | 1 | Wakeup method: 1 = address mark (MSB set), 0 = idle line |
| mute_wr | input | 1 | Write strobe for the mute bit |
| mute_val | input | 1 | Value written to the mute bit |
| data_rd | input | 1 | Read strobe of the receive data register |
| idle_clr | input | 1 | Clear pulse for the idle flag |
| irq_en_rx | input | 1 | Interrupt enable for full and overrun |
| irq_en_idle | input | 1 | Interrupt enable for idle line |
| rx_data | output | DATA_BITS | Receive data register |
| rx_full | output | 1 | Receive data register holds an unread word |
| rx_ovr | output | 1 | A word was lost to overrun |
| idle_flag | output | 1 | Idle line detected after a delivered word |
| mute_on | output | 1 | Receiver is muted |
| irq | output | 1 | Interrupt request |

## Verification
The read strobe and the delivery of a completed word can land in the same cycle. Depending on which one wins, the outcome is either a clean load or a spurious overrun. The bench provokes this by raising `data_rd` in the cycle right after the stop-bit tick of a second word, while the register still holds the first one. It then requires `rx_full`=1, `rx_ovr`=0 and `rx_data` equal to the second word. The scoreboard expects only the first word to produce a rising full flag.

// File: rtl/uart_mute_rx_pkg.sv
package uart_mute_rx_pkg;
  typedef enum logic [1:0] {
    RX_WAIT = 2'd0,
    RX_DATA = 2'd1,
    RX_STOP = 2'd2
  } rx_state_e;
endpackage

// File: rtl/urx_frame.sv
module urx_frame
  import uart_mute_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          bit_tick,
  input  logic          rx,
  output logic          word_vld,
  output logic [DW-1:0] word_data,
  output logic          waiting
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  rx_state_e     state;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] shreg;

  assign waiting = (state == RX_WAIT);

  always_ff @(posedge clk) begin
    word_vld <= 1'b0;
    if (rst || !rx_en) begin
      state     <= RX_WAIT;
      bit_cnt   <= '0;
      shreg     <= '0;
      word_data <= '0;
    end else if (bit_tick) begin
      case (state)
        RX_WAIT: begin
          if (!rx) begin
            state   <= RX_DATA;
            bit_cnt <= '0;
          end
        end
        RX_DATA: begin
          shreg <= {rx, shreg[DW-1:1]};
          if (bit_cnt == LAST_BIT) state <= RX_STOP;
          else                     bit_cnt <= bit_cnt + 1'b1;
        end
        RX_STOP: begin
          state <= RX_WAIT;
          if (rx) begin
            word_vld  <= 1'b1;
            word_data <= shreg;
          end
        end
        default: state <= RX_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/urx_idle_det.sv
module urx_idle_det #(
  parameter int IDLE_BITS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_en,
  input  logic bit_tick,
  input  logic rx,
  input  logic waiting,
  output logic idle_evt
);
  localparam int IW = $clog2(IDLE_BITS + 1);
  localparam logic [IW-1:0] HI_LAST = IW'(IDLE_BITS - 1);

  logic [IW-1:0] hi_cnt;
  logic          fired;

  always_ff @(posedge clk) begin
    idle_evt <= 1'b0;
    if (rst || !rx_en) begin
      hi_cnt <= '0;
      fired  <= 1'b0;
    end else if (!waiting) begin
      hi_cnt <= '0;
      fired  <= 1'b0;
    end else if (bit_tick) begin
      if (!rx) begin
        hi_cnt <= '0;
        fired  <= 1'b0;
      end else if (!fired) begin
        if (hi_cnt == HI_LAST) begin
          idle_evt <= 1'b1;
          fired    <= 1'b1;
          hi_cnt   <= '0;
        end else begin
          hi_cnt <= hi_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/urx_status.sv
module urx_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_vld,
  input  logic [DW-1:0] word_data,
  input  logic          idle_evt,
  input  logic          data_rd,
  input  logic          idle_clr,
  input  logic          mute_wr,
  input  logic          mute_val,
  input  logic          wake_addr,
  input  logic          irq_en_rx,
  input  logic          irq_en_idle,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          rx_ovr,
  output logic          idle_flag,
  output logic          mute_on,
  output logic          irq
);
  logic got_q, armed_q;
  logic full_n, ovr_n, idle_n, mute_n, got_n, armed_n, irq_n, load;
  logic addr_wake, line_wake, deliver, wr_ok;

  always_comb begin
    addr_wake = mute_on && wake_addr && word_vld && word_data[DW-1];
    line_wake = mute_on && !wake_addr && idle_evt;
    deliver   = word_vld && (!mute_on || addr_wake);
    wr_ok     = wake_addr ? !rx_full : (got_q || !mute_val);

    full_n  = rx_full;
    ovr_n   = rx_ovr;
    idle_n  = idle_flag;
    mute_n  = mute_on;
    armed_n = armed_q;
    got_n   = got_q | word_vld;
    load    = 1'b0;

    if (deliver && (!rx_full || data_rd)) begin
      load   = 1'b1;
      full_n = 1'b1;
    end else if (data_rd) begin
      full_n = 1'b0;
    end

    if (deliver && rx_full && !data_rd) ovr_n = 1'b1;
    else if (data_rd)                   ovr_n = 1'b0;

    if (deliver) armed_n = 1'b1;
    if (idle_evt && !mute_on && armed_q) begin
      idle_n  = 1'b1;
      armed_n = 1'b0;
    end else if (idle_clr) begin
      idle_n = 1'b0;
    end

    if (addr_wake || line_wake)  mute_n = 1'b0;
    else if (mute_wr && wr_ok)   mute_n = mute_val;

    irq_n = (irq_en_rx && (full_n || ovr_n)) || (irq_en_idle && idle_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data   <= '0;
      rx_full   <= 1'b0;
      rx_ovr    <= 1'b0;
      idle_flag <= 1'b0;
      mute_on   <= 1'b0;
      irq       <= 1'b0;
      got_q     <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      if (load) rx_data <= word_data;
      rx_full   <= full_n;
      rx_ovr    <= ovr_n;
      idle_flag <= idle_n;
      mute_on   <= mute_n;
      irq       <= irq_n;
      got_q     <= got_n;
      armed_q   <= armed_n;
    end
  end
endmodule

// File: rtl/uart_mute_rx.sv
module uart_mute_rx #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_tick,
  input  logic                 rx,
  input  logic                 rx_en,
  input  logic                 wake_addr,
  input  logic                 mute_wr,
  input  logic                 mute_val,
  input  logic                 data_rd,
  input  logic                 idle_clr,
  input  logic                 irq_en_rx,
  input  logic                 irq_en_idle,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_full,
  output logic                 rx_ovr,
  output logic                 idle_flag,
  output logic                 mute_on,
  output logic                 irq
);
  localparam int IDLE_BITS = DATA_BITS + 2;

  logic                 word_vld;
  logic [DATA_BITS-1:0] word_data;
  logic                 waiting;
  logic                 idle_evt;

  urx_frame #(.DW(DATA_BITS)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en),
    .bit_tick  (bit_tick),
    .rx        (rx),
    .word_vld  (word_vld),
    .word_data (word_data),
    .waiting   (waiting)
  );

  urx_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .rx_en    (rx_en),
    .bit_tick (bit_tick),
    .rx       (rx),
    .waiting  (waiting),
    .idle_evt (idle_evt)
  );

  urx_status #(.DW(DATA_BITS)) u_status (
    .clk         (clk),
    .rst         (rst),
    .word_vld    (word_vld),
    .word_data   (word_data),
    .idle_evt    (idle_evt),
    .data_rd     (data_rd),
    .idle_clr    (idle_clr),
    .mute_wr     (mute_wr),
    .mute_val    (mute_val),
    .wake_addr   (wake_addr),
    .irq_en_rx   (irq_en_rx),
    .irq_en_idle (irq_en_idle),
    .rx_data     (rx_data),
    .rx_full     (rx_full),
    .rx_ovr      (rx_ovr),
    .idle_flag   (idle_flag),
    .mute_on     (mute_on),
    .irq         (irq)
  );
endmodule

// File: rtl/uart_mute_rx_chk.sv
module uart_mute_rx_chk (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic data_rd,
  input logic mute_wr,
  input logic wake_addr,
  input logic word_vld,
  input logic word_msb,
  input logic rx_full,
  input logic rx_ovr,
  input logic idle_flag,
  input logic mute_on
);
  // R5: overrun only appears on top of an already full register
  a_r5_ovr_needs_full: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovr) |-> $past(rx_full));

  // R4: a read with no word handed over empties the register
  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !word_vld) |=> (!rx_full && !rx_ovr));

  // R8 / R10: no idle flag comes out of a muted state
  a_r8_no_idle_muted: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_flag) |-> !$past(mute_on));

  // R9: a delivery from mute is only an address-mark wakeup
  a_r9_addr_wake: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_full) && $past(mute_on)) |-> ($past(wake_addr) && $past(word_msb) && !mute_on));

  // R11: blocked write cannot mute the receiver
  a_r11_wr_blocked: assert property (@(posedge clk) disable iff (rst)
    (mute_wr && wake_addr && rx_full && !mute_on) |=> !mute_on);

  // R3: a disabled receiver delivers nothing
  a_r3_disabled: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !$past(rx_en)) |-> !$rose(rx_full));
endmodule

bind uart_mute_rx uart_mute_rx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_en     (rx_en),
  .data_rd   (data_rd),
  .mute_wr   (mute_wr),
  .wake_addr (wake_addr),
  .word_vld  (word_vld),
  .word_msb  (word_data[DATA_BITS-1]),
  .rx_full   (rx_full),
  .rx_ovr    (rx_ovr),
  .idle_flag (idle_flag),
  .mute_on   (mute_on)
);

// File: tb/test_uart_mute_rx.sv
module test_uart_mute_rx;
  localparam int DB = 8;
  localparam int IDLE_BITS = DB + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx = 1'b1, rx_en = 1'b0, wake_addr = 1'b0;
  logic mute_wr = 1'b0, mute_val = 1'b0, data_rd = 1'b0, idle_clr = 1'b0;
  logic irq_en_rx = 1'b0, irq_en_idle = 1'b0;
  logic [DB-1:0] rx_data;
  logic rx_full, rx_ovr, idle_flag, mute_on, irq;
  logic [2:0] tick_cnt = '0;
  logic bit_tick;

  int vecs = 0;
  int fails = 0;
  logic [DB-1:0] exp_q[$];
  logic prev_full = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) tick_cnt <= tick_cnt + 3'd1;
  assign bit_tick = (tick_cnt == 3'd7);

  uart_mute_rx #(.DATA_BITS(DB)) i_uart_mute_rx (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx(rx), .rx_en(rx_en),
    .wake_addr(wake_addr), .mute_wr(mute_wr), .mute_val(mute_val),
    .data_rd(data_rd), .idle_clr(idle_clr), .irq_en_rx(irq_en_rx),
    .irq_en_idle(irq_en_idle), .rx_data(rx_data), .rx_full(rx_full),
    .rx_ovr(rx_ovr), .idle_flag(idle_flag), .mute_on(mute_on), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: every rising full flag must match the next queued word
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_full && !prev_full) begin
        vecs++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2 scoreboard: actual %0h expected none", rx_data);
        end else begin
          logic [DB-1:0] e;
          e = exp_q.pop_front();
          if (rx_data !== e) begin
            fails++;
            $display("FAIL R2 scoreboard: actual %0h expected %0h", rx_data, e);
          end
        end
      end
      prev_full <= rx_full;
    end
  end

  task automatic wait_tick();
    while (!bit_tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic send(input logic [DB-1:0] d, input logic stop_ok);
    rx = 1'b0;
    wait_tick();
    for (int i = 0; i < DB; i++) begin
      rx = d[i];
      wait_tick();
    end
    rx = stop_ok;
    wait_tick();
    rx = 1'b1;
  endtask

  task automatic push_send(input logic [DB-1:0] d);
    exp_q.push_back(d);
    send(d, 1'b1);
  endtask

  task automatic idle_ticks(input int n);
    rx = 1'b1;
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic rd_pulse();
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
  endtask

  task automatic mute_write(input logic v);
    mute_val = v;
    mute_wr  = 1'b1;
    @(negedge clk);
    mute_wr  = 1'b0;
    settle();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    settle();
    chk("R1 rx_full", rx_full, 0);
    chk("R1 rx_ovr", rx_ovr, 0);
    chk("R1 idle_flag", idle_flag, 0);
    chk("R1 mute_on", mute_on, 0);
    chk("R1 irq", irq, 0);

    // R3: disabled receiver
    send(8'h55, 1'b1); settle();
    chk("R3 no word while disabled", rx_full, 0);
    idle_ticks(12); settle();
    chk("R3 no idle while disabled", idle_flag, 0);

    rx_en = 1'b1;
    idle_ticks(12); settle();
    chk("R6 no idle before any word", idle_flag, 0);

    // R12: mute refused before first word in idle-line mode
    wake_addr = 1'b0;
    mute_write(1'b1);
    chk("R12 mute refused before first word", mute_on, 0);

    irq_en_rx = 1'b1;
    push_send(8'hA5); settle();
    chk("R2 rx_full after word", rx_full, 1);
    chk("R7 irq on full", irq, 1);

    // R5: overrun
    send(8'h3C, 1'b1); settle();
    chk("R5 rx_ovr set", rx_ovr, 1);
    chk("R5 old word kept", rx_data, 8'hA5);
    rd_pulse();
    chk("R4 read clears full", rx_full, 0);
    chk("R4 read clears ovr", rx_ovr, 0);
    chk("R7 irq low when empty", irq, 0);

    // R6: idle boundary
    idle_ticks(IDLE_BITS - 1); settle();
    chk("R6 idle not yet", idle_flag, 0);
    idle_ticks(1); settle();
    chk("R6 idle after full frame", idle_flag, 1);
    chk("R7 irq masked idle", irq, 0);
    irq_en_idle = 1'b1; settle();
    chk("R7 irq on idle", irq, 1);
    idle_clr = 1'b1; @(negedge clk); idle_clr = 1'b0;
    chk("R6 idle_clr", idle_flag, 0);
    idle_ticks(12); settle();
    chk("R6 one idle per word", idle_flag, 0);
    irq_en_idle = 1'b0;

    // R2: bad stop bit
    send(8'h11, 1'b0); settle();
    chk("R2 framing error dropped", rx_full, 0);
    idle_ticks(2);

    // R4: read coinciding with completion
    push_send(8'h81); settle();
    send(8'h42, 1'b1);
    rd_pulse();
    chk("R4 coincident full", rx_full, 1);
    chk("R4 coincident no ovr", rx_ovr, 0);
    chk("R4 coincident data", rx_data, 8'h42);
    rd_pulse();

    // R8 / R10: idle-line wakeup
    mute_write(1'b1);
    chk("R12 mute accepted after word", mute_on, 1);
    send(8'h12, 1'b1); settle();
    chk("R8 muted no full", rx_full, 0);
    chk("R8 muted data kept", rx_data, 8'h42);
    chk("R8 still muted", mute_on, 1);
    idle_ticks(IDLE_BITS); settle();
    chk("R10 idle wakes", mute_on, 0);
    chk("R10 no idle flag on wake", idle_flag, 0);

    // R9 / R11: address-mark wakeup
    wake_addr = 1'b1;
    mute_write(1'b1);
    chk("R9 muted", mute_on, 1);
    send(8'h22, 1'b1); settle();
    chk("R8 no full on non-mark", rx_full, 0);
    chk("R9 stays muted on non-mark", mute_on, 1);
    push_send(8'h9A); settle();
    chk("R9 mark wakes", mute_on, 0);
    chk("R9 mark delivered", rx_full, 1);
    mute_write(1'b1);
    chk("R11 write ignored while full", mute_on, 0);
    rd_pulse();
    mute_write(1'b1);
    chk("R11 write accepted when empty", mute_on, 1);
    send(8'h7F, 1'b1); settle();
    chk("R8 muted drop", rx_full, 0);

    chk("R2 scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule